// File: doc/BRIEF.md
# Memory-Management Control Register Block

This block holds the software-visible control state of a paged memory-management unit. It sits on a 16-bit peripheral register bus with byte addresses. It holds three things: a mode configuration word, a memory-error status word and a table of map entries. The map entries relocate DMA addresses that peripherals present to memory. The block does not translate addresses itself. It holds the state and drives the enables and the map contents out to the translation logic.

Software writes the mode word to turn on separate data space for each privilege level, 22-bit physical addressing and the peripheral map. The error word latches a memory-error event signalled by the memory system, and software clears it by writing ones. Each map entry is 22 bits wide and is written as two 16-bit halves. Any access to an address the block does not own is answered with a bus timeout instead of data.

All bus results are registered. Read data and the timeout flag are valid in the cycle after the strobe. Writes take effect in the cycle after the strobe.

Top module: `mmu_ctl_regs`

## Requirements
- R1: A write to the mode address (default byte address 0x3F54E) sets the enables from the write data. Bit 0 is user data space, bit 1 is supervisor data space, bit 2 is kernel data space, bit 4 is 22-bit addressing and bit 5 is peripheral-map enable. The enables appear on `dspace_en[2:0]` (bit 0 user, bit 1 supervisor, bit 2 kernel), `addr22_en` and `pmap_en` one cycle after the strobe.
- R2: A read of the mode address returns the enables in the R1 bit positions, and every other bit reads zero.
- R3: A write to the error address (default 0x3FFE4) clears each error bit that is 1 in the write data and leaves the others unchanged. Only bit 10 can ever be set, and all other bits of the error word read zero.
- R4: A pulse on `mem_err_evt` sets bit 10 of the error word on the next clock edge.
- R5: If a software clear of bit 10 and a `mem_err_evt` pulse fall in the same cycle, bit 10 ends up set.
- R6: The map table has 32 entries of 22 bits each, starting at byte address 0x3F080. The entry index is taken from address bits 6:2, and address bit 1 selects the high half (1) or the low half (0). A low-half write replaces entry bits 15:0 and leaves bits 21:16 unchanged.
- R7: A high-half write replaces entry bits 21:16 with write data bits 5:0 and leaves bits 15:0 unchanged.
- R8: A read of a low half returns entry bits 15:0. A read of a high half returns entry bits 21:16 in data bits 5:0, with zeros above.
- R9: A read or write strobe to an address outside the mode word, the error word and the map region raises `bus_timeout` for one cycle. Such an access changes no state and returns zero read data. A decoded access never raises `bus_timeout`.
- R10: A `bus_init` pulse clears the mode enables and the error word and leaves the map table unchanged. If `bus_init` falls in the same cycle as a write or an error event, the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all state including the map table |
| bus_init | input | 1 | Synchronous bus-initialise pulse; clears the mode enables and the error word |
| addr | input | 18 | Byte address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| bus_timeout | output | 1 | Pulses the cycle after a strobe to an undecoded address |
| mem_err_evt | input | 1 | Memory-error event from the memory system |
| dspace_en | output | 3 | Data-space enables: bit 0 user, bit 1 supervisor, bit 2 kernel |
| addr22_en | output | 1 | 22-bit addressing enable |
| pmap_en | output | 1 | Peripheral-map enable |
| map_flat | output | 704 | All map entries concatenated; entry i occupies bits 22*i+21 down to 22*i |

## Verification
Every result of this block lands exactly one clock edge after its cause. Read data and the timeout flag are registered at the edge that samples the strobe. Writes, error events and `bus_init` change state at that same edge. The bench drives each strobe on a falling edge, holds it over one rising edge, and samples on the next falling edge, so every check falls in the first cycle the result is due. Checks that a half-write preserves the other half, and that an undecoded write changed nothing, are made by reading the affected word back over the same bus.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned N_PRIV  = 3;
    localparam int unsigned ERR_BIT = 10;

    // positions of the enables in the mode word
    localparam int unsigned MB_DSP0 = 0;
    localparam int unsigned MB_A22  = 4;
    localparam int unsigned MB_PMAP = 5;

    typedef struct packed {
        logic              pmap;
        logic              a22;
        logic [N_PRIV-1:0] dsp;
    } mode_t;

    typedef struct packed {
        logic hit_mode;
        logic hit_err;
        logic hit_map;
        logic miss;
    } dec_t;
endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned   ADDR_W    = 18,
    parameter int unsigned   N_ENT     = 32,
    parameter logic [17:0]   MODE_ADDR = 18'h3F54E,
    parameter logic [17:0]   ERR_ADDR  = 18'h3FFE4,
    parameter logic [17:0]   MAP_BASE  = 18'h3F080,
    localparam int unsigned  IDX_W     = $clog2(N_ENT),
    localparam int unsigned  RB        = IDX_W + 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc,
    output dec_t              dec,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    always_comb begin
        dec.hit_mode = (addr[ADDR_W-1:1] == MODE_ADDR[ADDR_W-1:1]);
        dec.hit_err  = (addr[ADDR_W-1:1] == ERR_ADDR[ADDR_W-1:1]);
        dec.hit_map  = (addr[ADDR_W-1:RB] == MAP_BASE[ADDR_W-1:RB]);
        dec.miss     = acc && !(dec.hit_mode || dec.hit_err || dec.hit_map);
        idx          = addr[RB-1:2];
        hi           = addr[1];
    end
endmodule

// File: rtl/mmu_ctl_cfg.sv
module mmu_ctl_cfg
    import mmu_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_init,
    input  logic              wr_mode,
    input  logic              wr_err,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mem_err_evt,
    output mode_t             mode,
    output logic [DATA_W-1:0] mode_word,
    output logic [DATA_W-1:0] err_word
);
    typedef struct packed {
        mode_t mode;
        logic  err;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.mode.dsp  = wdata[MB_DSP0 +: N_PRIV];
            st_d.mode.a22  = wdata[MB_A22];
            st_d.mode.pmap = wdata[MB_PMAP];
        end
        if (wr_err && wdata[ERR_BIT]) st_d.err = 1'b0;
        if (mem_err_evt)              st_d.err = 1'b1;   // set beats clear
        if (bus_init)                 st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mode_word                        = '0;
        mode_word[MB_DSP0 +: N_PRIV]     = st_q.mode.dsp;
        mode_word[MB_A22]                = st_q.mode.a22;
        mode_word[MB_PMAP]               = st_q.mode.pmap;
        err_word                         = '0;
        err_word[ERR_BIT]                = st_q.err;
        mode                             = st_q.mode;
    end

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err_evt && !bus_init) |=> err_word[ERR_BIT]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err_evt && wr_err && wdata[ERR_BIT] && !bus_init) |=> err_word[ERR_BIT]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && wdata[ERR_BIT] && !mem_err_evt) |=> !err_word[ERR_BIT]);
    p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> (mode_word == '0 && err_word == '0));
endmodule

// File: rtl/mmu_ctl_map.sv
module mmu_ctl_map
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned  N_ENT = 32,
    parameter int unsigned  ENT_W = 22,
    localparam int unsigned IDX_W = $clog2(N_ENT),
    localparam int unsigned HI_W  = ENT_W - DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic               hi,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_word,
    output logic [N_ENT*ENT_W-1:0] map_flat
);
    logic [ENT_W-1:0] ent_d [N_ENT];
    logic [ENT_W-1:0] ent_q [N_ENT];
    logic [ENT_W-1:0] sel_q;

    assign sel_q = ent_q[idx];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) ent_d[i] = ent_q[i];
        if (wr_en) begin
            if (hi) ent_d[idx][ENT_W-1:DATA_W] = wdata[HI_W-1:0];
            else    ent_d[idx][DATA_W-1:0]     = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        rd_word = '0;
        if (hi) rd_word[HI_W-1:0] = sel_q[ENT_W-1:DATA_W];
        else    rd_word           = sel_q[DATA_W-1:0];
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_flat
        assign map_flat[g*ENT_W +: ENT_W] = ent_q[g];
    end

    p_low_keeps_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hi) |=> (ent_q[$past(idx)][ENT_W-1:DATA_W] == $past(sel_q[ENT_W-1:DATA_W])));
    p_high_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi) |=> (ent_q[$past(idx)][DATA_W-1:0] == $past(sel_q[DATA_W-1:0])));
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned  ADDR_W    = 18,
    parameter int unsigned  N_ENT     = 32,
    parameter int unsigned  ENT_W     = 22,
    parameter logic [17:0]  MODE_ADDR = 18'h3F54E,
    parameter logic [17:0]  ERR_ADDR  = 18'h3FFE4,
    parameter logic [17:0]  MAP_BASE  = 18'h3F080,
    localparam int unsigned IDX_W     = $clog2(N_ENT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_init,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     bus_timeout,
    input  logic                     mem_err_evt,
    output logic [N_PRIV-1:0]        dspace_en,
    output logic                     addr22_en,
    output logic                     pmap_en,
    output logic [N_ENT*ENT_W-1:0]   map_flat
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tmo;
    } bus_t;

    dec_t              dec;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic              acc;
    mode_t             mode;
    logic [DATA_W-1:0] mode_word, err_word, map_word;
    bus_t              bus_d, bus_q;

    assign acc = rd_en || wr_en;

    mmu_ctl_decode #(
        .ADDR_W(ADDR_W), .N_ENT(N_ENT),
        .MODE_ADDR(MODE_ADDR), .ERR_ADDR(ERR_ADDR), .MAP_BASE(MAP_BASE)
    ) u_dec (
        .addr(addr), .acc(acc), .dec(dec), .idx(idx), .hi(hi)
    );

    mmu_ctl_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
        .wr_mode(wr_en && dec.hit_mode), .wr_err(wr_en && dec.hit_err),
        .wdata(wdata), .mem_err_evt(mem_err_evt),
        .mode(mode), .mode_word(mode_word), .err_word(err_word)
    );

    mmu_ctl_map #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && dec.hit_map),
        .idx(idx), .hi(hi), .wdata(wdata),
        .rd_word(map_word), .map_flat(map_flat)
    );

    always_comb begin
        bus_d       = '0;
        bus_d.tmo   = dec.miss;
        if (rd_en) begin
            if (dec.hit_mode)     bus_d.rdata = mode_word;
            else if (dec.hit_err) bus_d.rdata = err_word;
            else if (dec.hit_map) bus_d.rdata = map_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign rdata       = bus_q.rdata;
    assign bus_timeout = bus_q.tmo;
    assign dspace_en   = mode.dsp;
    assign addr22_en   = mode.a22;
    assign pmap_en     = mode.pmap;

    p_miss_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec.miss |=> (bus_timeout && rdata == '0));
    p_hit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.miss |=> !bus_timeout);
    p_mode_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.hit_mode) |=> (rdata[DATA_W-1:6] == '0 && rdata[3] == 1'b0));
    p_mode_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.hit_mode && !bus_init) |=> (dspace_en == $past(wdata[2:0])
            && addr22_en == $past(wdata[4]) && pmap_en == $past(wdata[5])));
endmodule

// File: tb/tb_mmu_ctl_regs.sv
module tb_mmu_ctl_regs;
    localparam logic [17:0] A_MODE = 18'h3F54E;
    localparam logic [17:0] A_ERR  = 18'h3FFE4;
    localparam logic [17:0] A_MAP  = 18'h3F080;

    logic clk = 1'b0, rst_n = 1'b0, bus_init = 1'b0;
    logic [17:0] addr = '0;
    logic rd_en = 1'b0, wr_en = 1'b0, mem_err_evt = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic bus_timeout, addr22_en, pmap_en;
    logic [2:0] dspace_en;
    logic [703:0] map_flat;

    int n_chk = 0, n_bad = 0;
    logic [15:0] rv;
    logic rt;

    always #4 clk = ~clk;

    mmu_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .bus_timeout(bus_timeout), .mem_err_evt(mem_err_evt),
        .dspace_en(dspace_en), .addr22_en(addr22_en), .pmap_en(pmap_en),
        .map_flat(map_flat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic evt = 1'b0);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; mem_err_evt = evt;
        @(negedge clk);
        wr_en = 1'b0; mem_err_evt = 1'b0;
        rt = bus_timeout;
    endtask

    task automatic rd(input logic [17:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rv = rdata; rt = bus_timeout;
    endtask

    function automatic logic [15:0] lo_pat(input int i);
        return 16'((i * 16'h0803) ^ 16'hA5C3);
    endfunction
    function automatic logic [5:0] hi_pat(input int i);
        return 6'((i * 7 + 3) & 6'h3F);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R1 reset dspace", {29'd0, dspace_en}, 0);
        check("R1 reset a22/pmap", {30'd0, addr22_en, pmap_en}, 0);
        rd(A_ERR);  check("R3 reset err", {16'd0, rv}, 0);
        rd(A_MAP + 18'd6); check("R8 reset map", {16'd0, rv}, 0);

        // R1/R2: all 64 combinations of the low six bits, with junk above
        for (int m = 0; m < 64; m++) begin
            logic [15:0] d;
            d = 16'(m) | 16'hFFC0;
            wr(A_MODE, d);
            check("R1 dspace_en", {29'd0, dspace_en}, 32'(m & 7));
            check("R1 addr22_en", {31'd0, addr22_en}, 32'((m >> 4) & 1));
            check("R1 pmap_en", {31'd0, pmap_en}, 32'((m >> 5) & 1));
            rd(A_MODE + 18'd1);
            check("R2 mode read", {16'd0, rv}, 32'(m & 6'h37));
            check("R9 mode no timeout", {31'd0, rt}, 0);
        end

        // R4/R3/R5: error word
        wr(A_ERR, 16'hFFFF, 1'b1);
        rd(A_ERR); check("R5 set beats clear", {16'd0, rv}, 32'h0400);
        wr(A_ERR, 16'hFBFF);
        rd(A_ERR); check("R3 other bits no effect", {16'd0, rv}, 32'h0400);
        wr(A_ERR, 16'h0400);
        rd(A_ERR); check("R3 w1c clears", {16'd0, rv}, 0);
        @(negedge clk); mem_err_evt = 1'b1; @(negedge clk); mem_err_evt = 1'b0;
        rd(A_ERR); check("R4 event sets bit10", {16'd0, rv}, 32'h0400);

        // R10: bus_init clears mode and error, keeps map
        wr(A_MODE, 16'h0037);
        wr(A_MAP + 18'd8, 16'h1234);
        @(negedge clk); bus_init = 1'b1; mem_err_evt = 1'b1;
        @(negedge clk); bus_init = 1'b0; mem_err_evt = 1'b0;
        check("R10 dspace cleared", {29'd0, dspace_en, 1'b0, addr22_en, pmap_en} , 0);
        rd(A_ERR);  check("R10 err cleared", {16'd0, rv}, 0);
        rd(A_MODE); check("R10 mode cleared", {16'd0, rv}, 0);
        rd(A_MAP + 18'd8); check("R10 map kept", {16'd0, rv}, 32'h1234);

        // R6/R7/R8: fill every entry, both halves, upper write bits are junk
        for (int i = 0; i < 32; i++) begin
            wr(A_MAP + 18'(i * 4), lo_pat(i));
            check("R9 map no timeout", {31'd0, rt}, 0);
            wr(A_MAP + 18'(i * 4) + 18'd2, 16'hFFC0 | 16'(hi_pat(i)));
        end
        for (int i = 0; i < 32; i++) begin
            rd(A_MAP + 18'(i * 4));
            check("R8 low read", {16'd0, rv}, {16'd0, lo_pat(i)});
            rd(A_MAP + 18'(i * 4) + 18'd2);
            check("R8 high read", {16'd0, rv}, {26'd0, hi_pat(i)});
            check("R8 flat", {10'd0, map_flat[i*22 +: 22]}, {10'd0, hi_pat(i), lo_pat(i)});
        end
        // rewrite low halves: high halves must survive
        for (int i = 0; i < 32; i++) wr(A_MAP + 18'(i * 4), ~lo_pat(i));
        for (int i = 0; i < 32; i++) begin
            rd(A_MAP + 18'(i * 4) + 18'd2);
            check("R6 high kept", {16'd0, rv}, {26'd0, hi_pat(i)});
            rd(A_MAP + 18'(i * 4));
            check("R6 low replaced", {16'd0, rv}, {16'd0, ~lo_pat(i)});
        end
        // rewrite high halves: low halves must survive
        for (int i = 0; i < 32; i++) wr(A_MAP + 18'(i * 4) + 18'd2, 16'(~hi_pat(i)));
        for (int i = 0; i < 32; i++) begin
            rd(A_MAP + 18'(i * 4));
            check("R7 low kept", {16'd0, rv}, {16'd0, ~lo_pat(i)});
            rd(A_MAP + 18'(i * 4) + 18'd2);
            check("R7 high replaced", {16'd0, rv}, {26'd0, 6'(~hi_pat(i))});
        end

        // R9: undecoded addresses
        wr(A_MODE, 16'h0015);
        begin
            logic [17:0] bad [4];
            bad[0] = A_MODE + 18'd2; bad[1] = 18'h00000;
            bad[2] = A_MAP + 18'h80; bad[3] = A_MAP - 18'd2;
            for (int k = 0; k < 4; k++) begin
                rd(bad[k]);
                check("R9 read timeout", {31'd0, rt}, 1);
                check("R9 read data zero", {16'd0, rv}, 0);
                wr(bad[k], 16'hFFFF);
                check("R9 write timeout", {31'd0, rt}, 1);
            end
        end
        rd(A_MODE); check("R9 mode untouched", {16'd0, rv}, 32'h0015);
        check("R9 timeout one cycle", {31'd0, bus_timeout}, 0);
        rd(A_MAP + 18'd2); check("R9 map untouched", {16'd0, rv}, {26'd0, 6'(~hi_pat(0))});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule